// File: doc/BRIEF.md
# Event Channel Status Flag Unit

This block holds the per-channel status flags of an eight-channel event routing fabric. Each channel sees an event pulse, a path-mode bit, and a ready and an acknowledge line from each of its consumers. When an event passes through a channel in synchronous mode, the block records it in an event flag. When the new event finds a consumer not ready, or a consumer that has not yet acknowledged the previous event, it also records an overrun. Channels in asynchronous mode leave every flag and every pending record untouched.

Software uses a small word-wide register port. A status word holds both flag groups and is cleared one bit at a time by writing ones. A separate pair of strobe addresses sets or clears the matching interrupt enables, and reading either address returns the enables. One registered, level-sensitive interrupt line is the OR of every flag whose enable is set.

Top module: `ev_status_flags`

## Requirements
- R1: The status word at offset 0x18 places channel c's event flag at bit 16+c and its overrun flag at bit c. Every other bit of every register reads 0. Flags, enables, read data and the interrupt are 0 after reset.
- R2: An accepted event (ev_pulse[c] high while ch_async[c] is low) sets the channel's event flag at the clock edge that samples it.
- R3: An event on a channel with ch_async[c] high sets neither flag of that channel and leaves its pending consumer records unchanged.
- R4: An accepted event sets the channel's overrun flag when any of that channel's four usr_ready lines (bits 4c to 4c+3) is low.
- R5: Each consumer keeps a pending bit. An accepted event sets all four bits of its channel, and usr_ack[4c+u] clears bit u. An accepted event that finds any pending bit of its channel set raises the overrun flag.
- R6: An event that raises an overrun also raises the event flag at the same edge.
- R7: A write to 0x18 clears each flag whose write-data bit is 1. Bits written as 0 leave their flags unchanged.
- R8: If a flag is set by an event and cleared by a write at the same edge, it ends up 1.
- R9: Writing 1s to offset 0x14 sets enable bits and writing 1s to offset 0x10 clears them. Enable bits use the same positions as the status word. A read of either address returns the current enables.
- R10: irq is registered and goes high one cycle after any flag and its enable are both 1. It stays high until every enabled flag is cleared or disabled.
- R11: A read (reg_sel high, reg_we low) returns data on reg_rdata one cycle later. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 8 | Per-channel event pulse |
| ch_async | input | 8 | Per-channel path mode, 1 = asynchronous |
| usr_ready | input | 32 | Consumer ready, four per channel |
| usr_ack | input | 32 | Consumer acknowledge, four per channel |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is a clean synchronous level sampled at the rising edge, with no unknown values once reset is released. They also assume that reg_addr and reg_wdata are meaningful only while reg_sel is high. The stimulus changes every input on the falling edge and holds ready lines high except in deliberate windows. Before each new scenario it acknowledges outstanding consumers, so that every overrun in the run is one the scenario intends.

// File: rtl/ev_status_flags_pkg.sv
package ev_status_flags_pkg;

  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam logic [7:0] OFS_EN_CLR = 8'h10;
  localparam logic [7:0] OFS_EN_SET = 8'h14;
  localparam logic [7:0] OFS_STATUS = 8'h18;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_EN_SET,
    SEL_EN_CLR
  } reg_sel_e;

  // Bits of the status/enable words that carry a flag.
  function automatic word_t build_flag_mask(input int nch, input int evd_lsb, input int ovr_lsb);
    word_t m;
    m = '0;
    for (int c = 0; c < nch; c++) begin
      m[evd_lsb + c] = 1'b1;
      m[ovr_lsb + c] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/evsf_consumer_track.sv
module evsf_consumer_track #(
  parameter int NUM_USR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [NUM_USR-1:0] ready,
  input  logic [NUM_USR-1:0] ack,
  output logic               overrun
);

  logic [NUM_USR-1:0] pend_q;
  logic               any_busy;
  logic               any_pend;

  assign any_busy = ~(&ready);
  assign any_pend = |pend_q;
  assign overrun  = accept & (any_busy | any_pend);

  // A new event re-arms every consumer; otherwise acks retire them.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (accept) begin
      pend_q <= '1;
    end else begin
      pend_q <= pend_q & ~ack;
    end
  end

endmodule

// File: rtl/evsf_flag_bank.sv
module evsf_flag_bank
  import ev_status_flags_pkg::*;
#(
  parameter word_t MASK = '1
) (
  input  logic  clk,
  input  logic  rst,
  input  word_t set_word,
  input  word_t clr_word,
  output word_t flags_q
);

  // Hardware set has priority over a software clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      flags_q <= (set_word | (flags_q & ~clr_word)) & MASK;
    end
  end

endmodule

// File: rtl/evsf_regif.sv
module evsf_regif
  import ev_status_flags_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter word_t      MASK       = '1,
  parameter logic [7:0] A_STATUS   = OFS_STATUS,
  parameter logic [7:0] A_EN_SET   = OFS_EN_SET,
  parameter logic [7:0] A_EN_CLR   = OFS_EN_CLR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  word_t             reg_wdata,
  input  word_t             flags_q,
  output word_t             clr_word,
  output word_t             en_q,
  output word_t             reg_rdata
);

  reg_sel_e dec;
  word_t    rd_mux;

  always_comb begin
    dec = SEL_NONE;
    if (reg_addr == ADDR_W'(A_STATUS))      dec = SEL_STATUS;
    else if (reg_addr == ADDR_W'(A_EN_SET)) dec = SEL_EN_SET;
    else if (reg_addr == ADDR_W'(A_EN_CLR)) dec = SEL_EN_CLR;
  end

  assign clr_word = (reg_sel && reg_we && dec == SEL_STATUS) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (reg_sel && reg_we) begin
      if (dec == SEL_EN_SET)      en_q <= (en_q | reg_wdata) & MASK;
      else if (dec == SEL_EN_CLR) en_q <= en_q & ~reg_wdata;
    end
  end

  always_comb begin
    case (dec)
      SEL_STATUS:             rd_mux = flags_q;
      SEL_EN_SET, SEL_EN_CLR: rd_mux = en_q;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_sel && !reg_we) begin
      reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/ev_status_flags.sv
module ev_status_flags
  import ev_status_flags_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_USR = 4,
  parameter int ADDR_W  = 8,
  parameter int EVD_LSB = 16,
  parameter int OVR_LSB = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CH-1:0]         ev_pulse,
  input  logic [NUM_CH-1:0]         ch_async,
  input  logic [NUM_CH*NUM_USR-1:0] usr_ready,
  input  logic [NUM_CH*NUM_USR-1:0] usr_ack,
  input  logic                      reg_sel,
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [WORD_W-1:0]         reg_wdata,
  output logic [WORD_W-1:0]         reg_rdata,
  output logic                      irq
);

  localparam word_t FLAG_MASK = build_flag_mask(NUM_CH, EVD_LSB, OVR_LSB);

  logic [NUM_CH-1:0] acc_ev;
  logic [NUM_CH-1:0] ovr_hit;
  word_t             set_word;
  word_t             clr_word;
  word_t             flags_q;
  word_t             en_q;
  logic              irq_q;

  assign acc_ev = ev_pulse & ~ch_async;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    evsf_consumer_track #(.NUM_USR(NUM_USR)) u_trk (
      .clk     (clk),
      .rst     (rst),
      .accept  (acc_ev[g]),
      .ready   (usr_ready[g*NUM_USR +: NUM_USR]),
      .ack     (usr_ack[g*NUM_USR +: NUM_USR]),
      .overrun (ovr_hit[g])
    );
  end

  always_comb begin
    set_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      set_word[EVD_LSB + c] = acc_ev[c];
      set_word[OVR_LSB + c] = ovr_hit[c];
    end
  end

  evsf_flag_bank #(.MASK(FLAG_MASK)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .set_word (set_word),
    .clr_word (clr_word),
    .flags_q  (flags_q)
  );

  evsf_regif #(.ADDR_W(ADDR_W), .MASK(FLAG_MASK)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags_q   (flags_q),
    .clr_word  (clr_word),
    .en_q      (en_q),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_q & en_q);
  end

  assign irq = irq_q;

endmodule

// File: rtl/ev_status_flags_chk.sv
module ev_status_flags_chk
  import ev_status_flags_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_USR = 4,
  parameter int ADDR_W  = 8,
  parameter int EVD_LSB = 16,
  parameter int OVR_LSB = 0
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CH-1:0]         ev_pulse,
  input logic [NUM_CH-1:0]         ch_async,
  input logic [NUM_CH*NUM_USR-1:0] usr_ready,
  input logic                      reg_sel,
  input logic                      reg_we,
  input logic [ADDR_W-1:0]         reg_addr,
  input word_t                     reg_wdata,
  input word_t                     reg_rdata,
  input logic                      irq,
  input word_t                     flags_q,
  input word_t                     en_q
);

  localparam word_t FLAG_MASK = build_flag_mask(NUM_CH, EVD_LSB, OVR_LSB);

  logic st_wr;
  assign st_wr = reg_sel && reg_we && (reg_addr == ADDR_W'(OFS_STATUS));

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~FLAG_MASK) == '0);

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> irq == $past(|(flags_q & en_q)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_evd_set_R2: assert property (@(posedge clk) disable iff (rst)
      $past(ev_pulse[c] && !ch_async[c]) |-> flags_q[EVD_LSB + c]);

    assert_async_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(ch_async[c]) && !$past(flags_q[EVD_LSB + c]) && !$past(flags_q[OVR_LSB + c]))
      |-> (!flags_q[EVD_LSB + c] && !flags_q[OVR_LSB + c]));

    assert_busy_overrun_R4: assert property (@(posedge clk) disable iff (rst)
      $past(ev_pulse[c] && !ch_async[c] && !(&usr_ready[c*NUM_USR +: NUM_USR]))
      |-> (flags_q[OVR_LSB + c] && flags_q[EVD_LSB + c]));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
      $past(st_wr && reg_wdata[EVD_LSB + c] && !(ev_pulse[c] && !ch_async[c]))
      |-> !flags_q[EVD_LSB + c]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      $past(st_wr && reg_wdata[EVD_LSB + c] && ev_pulse[c] && !ch_async[c])
      |-> flags_q[EVD_LSB + c]);
  end

endmodule

bind ev_status_flags ev_status_flags_chk #(
  .NUM_CH(NUM_CH), .NUM_USR(NUM_USR), .ADDR_W(ADDR_W), .EVD_LSB(EVD_LSB), .OVR_LSB(OVR_LSB)
) u_chk (
  .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .ch_async(ch_async), .usr_ready(usr_ready),
  .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq(irq), .flags_q(flags_q), .en_q(en_q)
);

// File: tb/ev_status_flags_tb.sv
module ev_status_flags_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ST  = 8'h18;
  localparam logic [7:0] A_SET = 8'h14;
  localparam logic [7:0] A_CLR = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ev_pulse = '0;
  logic [7:0]  ch_async = '0;
  logic [31:0] usr_ready = '1;
  logic [31:0] usr_ack = '0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  logic rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ev_status_flags u_dut (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .ch_async(ch_async),
    .usr_ready(usr_ready), .usr_ack(usr_ack), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Monitor: a read issued before a rising edge is compared at the next falling edge.
  always @(posedge clk) rd_flag <= reg_sel && !reg_we;

  always @(negedge clk) begin
    if (rd_flag) begin
      logic [31:0] e;
      string t;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: read data with no expected item, got %h", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    cyc();
    reg_sel = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic ev(input logic [7:0] m);
    ev_pulse = m;
    cyc();
    ev_pulse = '0;
  endtask

  task automatic ack(input logic [31:0] m);
    usr_ack = m;
    cyc();
    usr_ack = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();

    // R1 reset state, R11 unmapped read
    rd(A_ST, 32'h0, "R1");
    rd(A_SET, 32'h0, "R1");
    chk_irq(1'b0, "R1");
    rd(8'h04, 32'h0, "R11");

    // R2 event flag; R5/R6 second event without acks
    ev(8'h04);
    rd(A_ST, 32'h0004_0000, "R2");
    ev(8'h04);
    rd(A_ST, 32'h0004_0004, "R5");

    // R7 write-one-to-clear
    wr(A_ST, 32'h0);
    rd(A_ST, 32'h0004_0004, "R7");
    wr(A_ST, 32'h0004_0000);
    rd(A_ST, 32'h0000_0004, "R7");
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, 32'h0, "R7");

    // R5 full ack then event: no overrun; partial ack: overrun
    ack(32'h0000_0F00);
    ev(8'h04);
    rd(A_ST, 32'h0004_0000, "R5");
    ack(32'h0000_0700);
    ev(8'h04);
    rd(A_ST, 32'h0004_0004, "R5");
    wr(A_ST, 32'hFFFF_FFFF);
    ack(32'h0000_0F00);

    // R4 consumer not ready, R6 both flags
    usr_ready[21] = 1'b0;
    ev(8'h20);
    usr_ready = '1;
    rd(A_ST, 32'h0020_0020, "R4");
    wr(A_ST, 32'hFFFF_FFFF);
    ack(32'h00F0_0000);

    // R3 async channel: nothing set, pending untouched
    ch_async = 8'h08;
    ev(8'h08);
    rd(A_ST, 32'h0, "R3");
    ch_async = 8'h00;
    ev(8'h08);
    rd(A_ST, 32'h0008_0000, "R3");
    wr(A_ST, 32'hFFFF_FFFF);
    ack(32'h0000_F000);

    // R8 set wins over clear in the same cycle
    ev_pulse = 8'h01;
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = A_ST; reg_wdata = 32'h0001_0000;
    cyc();
    ev_pulse = '0; reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    rd(A_ST, 32'h0001_0000, "R8");
    wr(A_ST, 32'hFFFF_FFFF);
    ack(32'h0000_000F);

    // R9 enables, R10 interrupt
    wr(A_SET, 32'h0002_0000);
    rd(A_CLR, 32'h0002_0000, "R9");
    ev(8'h01);
    cyc();
    chk_irq(1'b0, "R10");
    ev(8'h02);
    chk_irq(1'b0, "R10");
    cyc();
    chk_irq(1'b1, "R10");
    wr(A_ST, 32'h0001_0000);
    cyc();
    chk_irq(1'b1, "R10");
    wr(A_CLR, 32'h0002_0000);
    cyc();
    chk_irq(1'b0, "R9");
    rd(A_SET, 32'h0, "R9");
    wr(A_SET, 32'h0000_0002);
    ev(8'h02);
    cyc();
    chk_irq(1'b1, "R10");
    wr(A_ST, 32'hFFFF_FFFF);
    cyc();
    chk_irq(1'b0, "R10");
    wr(A_SET, 32'hFFFF_FFFF);
    rd(A_SET, 32'h00FF_00FF, "R9");
    rd(A_ST, 32'h0, "R7");

    repeat (3) cyc();
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: pending reads actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end

endmodule